// File: doc/BRIEF.md
# Slew-Limited Phase-Error Loop Filter

This block sits between a phase detector and a digitally controlled oscillator in a clock-recovery loop. On each update tick, nominally 8 kHz, it takes a signed phase-error sample. First it passes the sample through a slew limiter. The limiter keeps a tracked error value, and that value may move toward the new sample by at most a fixed number of LSBs per tick. A large phase step is therefore spread over several ticks and never reaches the filter in one update. The tracked value then drives a single-pole IIR low-pass filter. The integer part of the filter output is the frequency-correction word for the oscillator. The filter bandwidth is set only by a shift parameter, so it is the same whatever reference rate feeds the phase detector. The default shift of 10 at an 8 kHz tick gives a corner of roughly 1.2 to 1.5 Hz.

The default step limit is 4 LSB per tick. With a 1 ns LSB this is the per-tick share of a 41 ns movement per 1.326 ms. A freeze input serves holdover and freerun operation. While freeze is high, ticks are ignored and the correction word stays at its last value. A flag reports each tick on which the limiter had to cut the movement.

Top module: `slew_loop_filter`

## Requirements
- R1: Synchronous reset (`rst` high) clears the tracked error, the filter accumulator, `corrWord` and `limitActive` to zero.
- R2: On an accepted tick (`updateTick` high, `freeze` low), the tracked error L moves to the sample E when |E−L| ≤ STEP_MAX. Otherwise it moves by exactly +STEP_MAX or −STEP_MAX toward E.
- R3: `limitActive` becomes 1 after an accepted tick with |E−L| > STEP_MAX and becomes 0 after an accepted tick with |E−L| ≤ STEP_MAX. It keeps its value between ticks.
- R4: On an accepted tick the accumulator S becomes S + L' − floor(S / 2^SHIFT_K), where L' is the new tracked error. `corrWord` equals floor(S / 2^SHIFT_K) and shows the new value in the cycle after the tick.
- R5: A tick with `freeze` high leaves the tracked error, the accumulator and `corrWord` unchanged and clears `limitActive`.
- R6: When `updateTick` is low, no state and no output changes, whatever `phaseErr` and `freeze` do.
- R7: A step in the error larger than STEP_MAX is spread over ceil(|step| / STEP_MAX) ticks, in both directions. `limitActive` stays high on every tick except the final partial step.
- R8: Sustained full-scale positive or negative error drives `corrWord` to that same full-scale value without wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| updateTick | input | 1 | One-cycle strobe that marks a new phase-error sample |
| freeze | input | 1 | Hold request for holdover and freerun; while high, samples are ignored |
| phaseErr | input | ERR_W | Signed phase-error sample, two's complement |
| corrWord | output | ERR_W | Signed frequency-correction word for the oscillator |
| limitActive | output | 1 | High after a tick on which the slew limiter cut the movement |

## Verification
Limiting and freezing can both apply to the same tick. The bench provokes this by raising `freeze` together with a tick whose error sits far beyond the step limit. Freeze must win: `corrWord` stays at its value and `limitActive` is cleared even though the sample alone would have set it. Limiting and filter update also fall in the same cycle on every accepted tick. Sweeping every possible error value from several tracked states makes a bench-side model of the clamp and the shift-based filter catch any wrong clamp boundary, including the exact ±STEP_MAX edges.

// File: rtl/slf_pkg.sv
package slf_pkg;

  // Strobes from the control module to the datapath, one cycle wide.
  typedef struct packed {
    logic accept;      // sample is taken: limiter and filter advance
    logic frozenTick;  // tick arrived during freeze: hold, clear flag
  } slfStrobe_t;

endpackage

// File: rtl/slf_ctrl.sv
module slf_ctrl
  import slf_pkg::*;
(
  input  logic       updateTick,
  input  logic       freeze,
  output slfStrobe_t strobe
);

  always_comb begin
    strobe.accept     = updateTick & ~freeze;
    strobe.frozenTick = updateTick & freeze;
  end

endmodule

// File: rtl/slf_datapath.sv
module slf_datapath
  import slf_pkg::*;
#(
  parameter int ERR_W    = 16,
  parameter int STEP_MAX = 4,
  parameter int SHIFT_K  = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  slfStrobe_t              strobe,
  input  logic signed [ERR_W-1:0] phaseErr,
  output logic signed [ERR_W-1:0] corrWord,
  output logic                    limitActive,
  output logic signed [ERR_W-1:0] limVal
);

  // One extra bit holds the difference of two ERR_W values.
  localparam int DIFF_W = ERR_W + 1;
  // The accumulator holds SHIFT_K fraction bits plus guard bits.
  // |S| stays below 2^SHIFT_K * (2^(ERR_W-1) + 1).
  localparam int ACC_W  = ERR_W + SHIFT_K + 2;
  localparam logic signed [DIFF_W-1:0] STEP_POS = DIFF_W'(STEP_MAX);
  localparam logic signed [DIFF_W-1:0] STEP_NEG = -STEP_POS;

  logic signed [ERR_W-1:0]  limQ;
  logic signed [DIFF_W-1:0] errExt;
  logic signed [DIFF_W-1:0] limExt;
  logic signed [DIFF_W-1:0] diff;
  logic signed [DIFF_W-1:0] stepSel;
  logic signed [DIFF_W-1:0] limSum;
  logic signed [ERR_W-1:0]  limD;
  logic                     overHi;
  logic                     overLo;

  logic signed [ACC_W-1:0]  accQ;
  logic signed [ACC_W-1:0]  accIn;
  logic signed [ACC_W-1:0]  accDecay;
  logic signed [ACC_W-1:0]  accNext;
  logic                     flagQ;

  // Slew limiter: the tracked error moves toward the sample by at most STEP_MAX.
  always_comb begin
    errExt  = {phaseErr[ERR_W-1], phaseErr};
    limExt  = {limQ[ERR_W-1], limQ};
    diff    = errExt - limExt;
    overHi  = (diff > STEP_POS);
    overLo  = (diff < STEP_NEG);
    if (overHi)      stepSel = STEP_POS;
    else if (overLo) stepSel = STEP_NEG;
    else             stepSel = diff;
    limSum  = limExt + stepSel;
    // The sum lies between the old tracked value and the sample, so it fits ERR_W.
    limD    = limSum[ERR_W-1:0];
  end

  // Single-pole low-pass filter in fractional form: S += L - S/2^K.
  always_comb begin
    accIn    = {{(ACC_W-ERR_W){limD[ERR_W-1]}}, limD};
    accDecay = accQ >>> SHIFT_K;
    accNext  = accQ + accIn - accDecay;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      limQ  <= '0;
      accQ  <= '0;
      flagQ <= 1'b0;
    end else if (strobe.accept) begin
      limQ  <= limD;
      accQ  <= accNext;
      flagQ <= overHi | overLo;
    end else if (strobe.frozenTick) begin
      flagQ <= 1'b0;
    end
  end

  // The integer part of S is bounded by the input range, so the slice cannot wrap.
  assign corrWord    = accQ[SHIFT_K +: ERR_W];
  assign limitActive = flagQ;
  assign limVal      = limQ;

endmodule

// File: rtl/slew_loop_filter.sv
module slew_loop_filter
  import slf_pkg::*;
#(
  parameter int ERR_W    = 16,
  parameter int STEP_MAX = 4,
  parameter int SHIFT_K  = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    updateTick,
  input  logic                    freeze,
  input  logic signed [ERR_W-1:0] phaseErr,
  output logic signed [ERR_W-1:0] corrWord,
  output logic                    limitActive
);

  slfStrobe_t              strobe;
  logic signed [ERR_W-1:0] limVal;

  slf_ctrl u_ctrl (
    .updateTick (updateTick),
    .freeze     (freeze),
    .strobe     (strobe)
  );

  slf_datapath #(
    .ERR_W    (ERR_W),
    .STEP_MAX (STEP_MAX),
    .SHIFT_K  (SHIFT_K)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .phaseErr    (phaseErr),
    .corrWord    (corrWord),
    .limitActive (limitActive),
    .limVal      (limVal)
  );

endmodule

// File: rtl/slf_checker.sv
module slf_checker #(
  parameter int ERR_W    = 16,
  parameter int STEP_MAX = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    updateTick,
  input logic                    freeze,
  input logic signed [ERR_W-1:0] corrWord,
  input logic                    limitActive,
  input logic signed [ERR_W-1:0] limVal
);

  localparam logic signed [ERR_W:0] STEP_S = (ERR_W+1)'(STEP_MAX);

  logic signed [ERR_W:0] limWide;
  logic                  rstSeen;

  assign limWide = {limVal[ERR_W-1], limVal};

  always_ff @(posedge clk) rstSeen <= rst;

  // R1
  always @(negedge clk) begin
    if (rstSeen === 1'b1) begin
      reset_clear_chk: assert (corrWord == '0 && !limitActive && limVal == '0)
        else $error("reset did not clear the filter state");
    end
  end

  // R2
  step_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (updateTick && !freeze) |=>
      ((limWide - $past(limWide)) <= STEP_S) && ((limWide - $past(limWide)) >= -STEP_S));

  // R3
  flag_step_chk: assert property (@(posedge clk) disable iff (rst)
    (updateTick && !freeze) |=>
      (limitActive |-> ((limWide - $past(limWide)) == STEP_S ||
                        (limWide - $past(limWide)) == -STEP_S)));

  // R5
  freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (updateTick && freeze) |=> $stable(corrWord) && $stable(limVal) && !limitActive);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !updateTick |=> $stable(corrWord) && $stable(limVal) && $stable(limitActive));

endmodule

bind slew_loop_filter slf_checker #(
  .ERR_W    (ERR_W),
  .STEP_MAX (STEP_MAX)
) u_slf_chk (
  .clk         (clk),
  .rst         (rst),
  .updateTick  (updateTick),
  .freeze      (freeze),
  .corrWord    (corrWord),
  .limitActive (limitActive),
  .limVal      (limVal)
);

// File: tb/slew_loop_filter_bench.sv
module slew_loop_filter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ERR_W      = 8;
  localparam int STEP_MAX   = 3;
  localparam int SHIFT_K    = 3;
  localparam int MAX_V      = (1 << (ERR_W - 1)) - 1;
  localparam int MIN_V      = -(1 << (ERR_W - 1));

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    updateTick = 1'b0;
  logic                    freeze = 1'b0;
  logic signed [ERR_W-1:0] phaseErr = '0;
  logic signed [ERR_W-1:0] corrWord;
  logic                    limitActive;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bench model of the requirements.
  longint mLim  = 0;
  longint mAcc  = 0;
  bit     mFlag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slew_loop_filter #(
    .ERR_W    (ERR_W),
    .STEP_MAX (STEP_MAX),
    .SHIFT_K  (SHIFT_K)
  ) u_slew_loop_filter (
    .clk         (clk),
    .rst         (rst),
    .updateTick  (updateTick),
    .freeze      (freeze),
    .phaseErr    (phaseErr),
    .corrWord    (corrWord),
    .limitActive (limitActive)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint mCorr();
    return mAcc >>> SHIFT_K;
  endfunction

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    updateTick = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    mLim = 0; mAcc = 0; mFlag = 1'b0;
    check("R1", "corrWord", longint'(corrWord), 0);
    check("R1", "limitActive", longint'(limitActive), 0);
  endtask

  task automatic applyTick(input int e, input bit frz, input string req);
    longint d;
    @(negedge clk);
    updateTick = 1'b1;
    freeze     = frz;
    phaseErr   = ERR_W'(e);
    @(negedge clk);
    updateTick = 1'b0;
    if (frz) begin
      mFlag = 1'b0;
    end else begin
      d = longint'(e) - mLim;
      if (d > STEP_MAX)       begin mLim = mLim + STEP_MAX; mFlag = 1'b1; end
      else if (d < -STEP_MAX) begin mLim = mLim - STEP_MAX; mFlag = 1'b1; end
      else                    begin mLim = e;               mFlag = 1'b0; end
      mAcc = mAcc + mLim - (mAcc >>> SHIFT_K);
    end
    check(req, "corrWord", longint'(corrWord), mCorr());
    check("R3", "limitActive", longint'(limitActive), longint'(mFlag));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic signed [ERR_W-1:0] heldCorr;
    logic                    heldFlag;

    doReset();

    // R2 R4: every error value, starting from a tracked value that keeps moving.
    for (int e = MIN_V; e <= MAX_V; e++) applyTick(e, 1'b0, "R2");
    // R2 R4: scattered values make large jumps in both directions.
    for (int i = 0; i < 256; i++) applyTick(((i * 37) % 256) + MIN_V, 1'b0, "R4");
    // R2: exact clamp edges around a settled tracked value.
    for (int i = 0; i < 8; i++) applyTick(10, 1'b0, "R2");
    for (int o = -STEP_MAX - 2; o <= STEP_MAX + 2; o++) begin
      applyTick(10, 1'b0, "R2");
      applyTick(10, 1'b0, "R2");
      applyTick(10 + o, 1'b0, "R2");
    end

    // R5: freeze on a tick whose error would be limited.
    for (int i = 0; i < 4; i++) applyTick(MAX_V, 1'b0, "R7");
    heldCorr = corrWord;
    applyTick(MIN_V, 1'b1, "R5");
    check("R5", "frozen corrWord", longint'(corrWord), longint'(heldCorr));
    check("R5", "frozen flag", longint'(limitActive), 0);
    for (int i = 0; i < 5; i++) applyTick(MIN_V + i * 50, 1'b1, "R5");
    check("R5", "held corrWord", longint'(corrWord), longint'(heldCorr));
    applyTick(mLim + 1, 1'b0, "R5");

    // R6: no tick, so phaseErr and freeze changes have no effect.
    applyTick(MAX_V, 1'b0, "R6");
    heldCorr = corrWord;
    heldFlag = limitActive;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      phaseErr = ERR_W'(i * 41 - 100);
      freeze   = i[0];
    end
    @(negedge clk);
    check("R6", "idle corrWord", longint'(corrWord), longint'(heldCorr));
    check("R6", "idle flag", longint'(limitActive), longint'(heldFlag));
    freeze = 1'b0;

    // R8: sustained full scale in both directions.
    for (int i = 0; i < 200; i++) applyTick(MAX_V, 1'b0, "R8");
    check("R8", "full positive", longint'(corrWord), MAX_V);
    // R7: the full-range step is spread over ceil(255/3)=85 ticks.
    for (int i = 0; i < 85; i++) begin
      applyTick(MIN_V, 1'b0, "R7");
      check("R7", "flag during spread", longint'(limitActive), (i < 84) ? 1 : 0);
    end
    for (int i = 0; i < 200; i++) applyTick(MIN_V, 1'b0, "R8");
    check("R8", "full negative", longint'(corrWord), MIN_V);
    // R7: an upward step of 10 needs four ticks, the last one partial.
    for (int i = 0; i < 4; i++) begin
      applyTick(MIN_V + 10, 1'b0, "R7");
      check("R7", "upward flag", longint'(limitActive), (i < 3) ? 1 : 0);
    end

    // R1: reset in mid-operation clears everything again.
    doReset();
    applyTick(2, 1'b0, "R1");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule